// File: doc/BRIEF.md
# Sequential Signed Shift-Add Multiplier

This block multiplies two two's-complement operands of `WIDTH` bits and returns their signed product in `2*WIDTH` bits. It takes one multiplier bit per clock. A single adder one bit wider than the operands accumulates a running partial product. After each step the partial product is shifted one place right with its sign bit copied. For every multiplier bit except the top one, the multiplicand is added when the bit is 1. For the top (sign) bit it is subtracted instead. Signed operands therefore need no negation before or after the multiply.

A caller raises `start` for one cycle together with the two operands while the block is idle. `busy` stays high for the whole run. `done` pulses for one cycle when the product is ready. The product then stays on `product` until the next accepted start. A start raised while `busy` is high is dropped. The reset is synchronous and active low.

Top module: `seq_signed_mult`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block goes idle: after that edge `busy` = 0, `done` = 0 and `product` = 0, including when a multiply was in progress.
- R2: A `start` sampled high while `busy` is low is accepted, and `busy` is high from the next cycle.
- R3: `done` rises exactly `WIDTH` clock cycles after the edge that accepted `start` and is high for exactly one cycle. `busy` is low in the cycle where `done` is high.
- R4: When `done` is high, `product`, read as a 2*`WIDTH`-bit two's-complement number, equals the signed product of the two operands captured at start.
- R5: The most negative operand multiplied by itself gives the correct positive product, 2^(2*`WIDTH`-2).
- R6: A `start` raised while `busy` is high is ignored. The running multiply keeps its operands and its timing, and no extra `done` follows.
- R7: While idle with `start` low, `product` holds its last value.
- R8: `op_a` and `op_b` are sampled only at the accepting edge. Changing them during a run does not affect the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request a multiply; sampled only while idle |
| op_a | input | WIDTH | Multiplicand, two's complement |
| op_b | input | WIDTH | Multiplier, two's complement |
| busy | output | 1 | High while a multiply is running |
| done | output | 1 | One-cycle pulse when the product is ready |
| product | output | 2*WIDTH | Signed product; valid from `done` until the next start |

## Verification
A wrong step count or a bad last-step flag appears at the ports in the same run. `done` arrives at the wrong cycle, or the product is off by twice the multiplicand times 2^(`WIDTH`-1) for every operand whose multiplier sign bit is set. An error in the sign handling of the widened sum shows only in the sign and top bits of the product. Operand pairs with negative partial products are the ones that catch it, so the sweep covers every operand pair of a small configuration. A corrupted multiplicand or multiplier register shows at the next `done`, at most `WIDTH` cycles after the fault. An idle-state fault shows as a product that drifts between runs or as a `done` with no start before it.

// File: rtl/seq_mult_pkg.sv
// Shared types for the sequential signed multiplier.
// Assumes nothing beyond a two-state run/idle sequencer.
package seq_mult_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } mult_state_e;
endpackage

// File: rtl/mult_seq_ctrl.sv
// Sequencer: accepts a start while idle, counts WIDTH step cycles,
// flags the final (sign-bit) step and issues a registered done pulse.
// Assumes WIDTH >= 2.
module mult_seq_ctrl
    import seq_mult_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic last,
    output logic busy,
    output logic done
);
    localparam int CNT_W = (WIDTH > 2) ? $clog2(WIDTH) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WIDTH - 1);

    mult_state_e      state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             done_q;

    // Decode the current cycle's action from the state and step count.
    always_comb begin
        load = (state_q == ST_IDLE) && start;
        step = (state_q == ST_RUN);
        last = step && (cnt_q == LAST_IDX);
    end

    // Advance the state and step count, and register the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= last;
            if (load) begin
                state_q <= ST_RUN;
                cnt_q   <= '0;
            end else if (step) begin
                cnt_q <= cnt_q + 1'b1;
                if (last) begin
                    state_q <= ST_IDLE;
                end
            end
        end
    end

    assign busy = (state_q == ST_RUN);
    assign done = done_q;
endmodule

// File: rtl/mult_addsub.sv
// One-bit-wider adder/subtractor for the partial product. The extra
// bit keeps the sign of the sum correct before the arithmetic shift.
// Assumes both inputs are two's complement.
module mult_addsub #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] acc,
    input  logic [WIDTH-1:0] mcand,
    input  logic             use_mcand,
    input  logic             subtract,
    output logic [WIDTH:0]   sum
);
    logic [WIDTH:0] acc_ext;
    logic [WIDTH:0] opnd_ext;

    // Sign-extend both sides and add or subtract the selected operand.
    always_comb begin
        acc_ext  = {acc[WIDTH-1], acc};
        opnd_ext = use_mcand ? {mcand[WIDTH-1], mcand} : '0;
        sum      = subtract ? (acc_ext - opnd_ext) : (acc_ext + opnd_ext);
    end
endmodule

// File: rtl/mult_datapath.sv
// Multiplicand register, multiplier shift register and partial-product
// register. Each step folds one multiplier bit into the partial product
// and shifts the pair right by one. Assumes the controller asserts
// load and step in separate cycles.
module mult_datapath #(
    parameter int WIDTH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               step,
    input  logic               last,
    input  logic [WIDTH-1:0]   op_a,
    input  logic [WIDTH-1:0]   op_b,
    output logic [2*WIDTH-1:0] product
);
    logic [WIDTH-1:0] mcand_q;
    logic [WIDTH-1:0] acc_q;
    logic [WIDTH-1:0] mlt_q;
    logic [WIDTH:0]   sum;

    mult_addsub #(.WIDTH(WIDTH)) u_addsub (
        .acc       (acc_q),
        .mcand     (mcand_q),
        .use_mcand (mlt_q[0]),
        .subtract  (last),
        .sum       (sum)
    );

    // Capture the operands on load; shift in the new partial product on each step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcand_q <= '0;
            acc_q   <= '0;
            mlt_q   <= '0;
        end else if (load) begin
            mcand_q <= op_a;
            acc_q   <= '0;
            mlt_q   <= op_b;
        end else if (step) begin
            acc_q <= sum[WIDTH:1];
            mlt_q <= {sum[0], mlt_q[WIDTH-1:1]};
        end
    end

    assign product = {acc_q, mlt_q};
endmodule

// File: rtl/seq_signed_mult.sv
// Top level of the sequential signed shift-add multiplier: WIDTH-bit
// two's-complement operands in, 2*WIDTH-bit signed product out after
// WIDTH step cycles. Assumes WIDTH >= 2 and a synchronous active-low reset.
module seq_signed_mult #(
    parameter int WIDTH = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [WIDTH-1:0]     op_a,
    input  logic [WIDTH-1:0]     op_b,
    output logic                 busy,
    output logic                 done,
    output logic [2*WIDTH-1:0]   product
);
    logic load;
    logic step;
    logic last;

    mult_seq_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load),
        .step  (step),
        .last  (last),
        .busy  (busy),
        .done  (done)
    );

    mult_datapath #(.WIDTH(WIDTH)) u_dp (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .step    (step),
        .last    (last),
        .op_a    (op_a),
        .op_b    (op_b),
        .product (product)
    );
endmodule

// File: rtl/seq_signed_mult_chk.sv
// Port-level checker for seq_signed_mult, attached by bind. It keeps its
// own copy of the accepted operands and a count of run cycles.
module seq_signed_mult_chk #(
    parameter int WIDTH = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic [WIDTH-1:0]   op_a,
    input logic [WIDTH-1:0]   op_b,
    input logic               busy,
    input logic               done,
    input logic [2*WIDTH-1:0] product
);
    localparam int CW = $clog2(WIDTH + 1) + 1;

    logic [WIDTH-1:0]          cap_a;
    logic [WIDTH-1:0]          cap_b;
    logic [CW-1:0]             run_cnt;
    logic signed [2*WIDTH-1:0] ext_a;
    logic signed [2*WIDTH-1:0] ext_b;
    logic signed [2*WIDTH-1:0] exp_prod;

    // Record the accepted operands and count the cycles spent busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_a   <= '0;
            cap_b   <= '0;
            run_cnt <= '0;
        end else if (start && !busy) begin
            cap_a   <= op_a;
            cap_b   <= op_b;
            run_cnt <= '0;
        end else if (busy) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    assign ext_a    = {{WIDTH{cap_a[WIDTH-1]}}, cap_a};
    assign ext_b    = {{WIDTH{cap_b[WIDTH-1]}}, cap_b};
    assign exp_prod = ext_a * ext_b;

    assert_start_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_done_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_cnt == CW'(WIDTH)));

    assert_product_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($signed(product) == exp_prod));

    assert_product_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(product));
endmodule

bind seq_signed_mult seq_signed_mult_chk #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .op_a    (op_a),
    .op_b    (op_b),
    .busy    (busy),
    .done    (done),
    .product (product)
);

// File: tb/test_seq_signed_mult.sv
module test_seq_signed_mult;
    localparam int TW = 6;
    localparam int PW = 2 * TW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [TW-1:0] op_a = '0;
    logic [TW-1:0] op_b = '0;
    logic          busy;
    logic          done;
    logic [PW-1:0] product;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;

    seq_signed_mult #(.WIDTH(TW)) i_seq_signed_mult (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .op_a    (op_a),
        .op_b    (op_b),
        .busy    (busy),
        .done    (done),
        .product (product)
    );

    always #2 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles, expected fewer than 150000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One multiply; optionally disturbs operands and raises start while busy.
    task automatic run_mult(input int ia, input int ib, input bit disturb);
        int lat;
        int got;
        @(negedge clk);
        start = 1'b1;
        op_a  = TW'(ia);
        op_b  = TW'(ib);
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R2 busy after start", int'(busy), 1);
        if (disturb) begin
            op_a = ~op_a;   // R8: changes during the run must not matter
            op_b = op_b + 1'b1;
        end
        lat = 0;
        while (!done && lat < TW + 4) begin
            @(negedge clk);
            lat++;
            if (disturb && lat == 2) begin
                start = 1'b1;   // R6: start while busy is ignored
                op_a  = TW'(ia + 3);
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        chk(lat == TW, "R3 done latency", lat, TW);
        chk(busy == 1'b0, "R3 busy low with done", int'(busy), 0);
        got = $signed(product);
        chk(got == ia * ib, disturb ? "R4/R6/R8 product" : "R4 product", got, ia * ib);
        @(negedge clk);
        chk(done == 1'b0, "R3 done single cycle", int'(done), 0);
    endtask

    initial begin
        int held;
        // R1: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R1 busy at reset", int'(busy), 0);
        chk(done == 1'b0, "R1 done at reset", int'(done), 0);
        chk(product == '0, "R1 product at reset", int'(product), 0);

        // R5: most negative squared
        run_mult(-(1 << (TW - 1)), -(1 << (TW - 1)), 1'b0);
        chk($signed(product) == (1 << (PW - 2)), "R5 min*min",
            $signed(product), 1 << (PW - 2));

        // R7: product holds while idle, inputs moving, start low
        held = $signed(product);
        op_a = 6'h15;
        op_b = 6'h2a;
        repeat (5) @(negedge clk);
        chk($signed(product) == held, "R7 product hold", $signed(product), held);
        chk(done == 1'b0, "R6 no extra done", int'(done), 0);

        // R4: exhaustive sweep, some runs disturbed (R6, R8)
        for (int ia = -(1 << (TW - 1)); ia < (1 << (TW - 1)); ia++) begin
            for (int ib = -(1 << (TW - 1)); ib < (1 << (TW - 1)); ib++) begin
                run_mult(ia, ib, ((ia + ib) & 7) == 0);
            end
        end

        // R1: reset in the middle of a run
        @(negedge clk);
        start = 1'b1;
        op_a  = 6'h1f;
        op_b  = 6'h1f;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk(busy == 1'b0, "R1 busy after mid-run reset", int'(busy), 0);
        chk(product == '0, "R1 product after mid-run reset", int'(product), 0);
        repeat (TW + 2) begin
            @(negedge clk);
            chk(done == 1'b0, "R1 no done after reset", int'(done), 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule